// File: doc/BRIEF.md
# DMA Channel Status and Interrupt Aggregator

This block keeps one 32-bit control/status word for each of `NUM_CH` DMA channels and derives the controller's interrupt from those words. Software writes a word by channel number. A write can clear selected flags by writing ones to them, loads a group of control bits, and can set or clear the compare flag through two separate strobe bits. The channel engines report events through single-cycle pulses: start, end, stopped, end-of-receive, request-after-stop and bus error. Each channel also supplies a live request level, which the block shows in the read value.

The stored control bits go back to the engines as per-channel run, no-descriptor-fetch, end-of-receive-stop and end-of-receive-jump outputs. Each channel computes its own interrupt bit. The start and end flags count on their own. The stopped, end-of-receive and request-after-stop flags count only when their enable bit is set. The per-channel bits form a summary word, and their OR drives a single interrupt line.

Top module: `dma_stat_agg`

## Requirements
- R1: After reset, every channel reads 0x00000008 (stopped flag only), all control outputs are 0, `sum_o` is 0 and `irq_o` is low.
- R2: On a write, the status bits 0 (bus error), 1 (start), 2 (end) and 9 (end-of-receive) are cleared where the written value has a 1. The bits 3 (stopped), 4 (request-after-stop) and 10 (compare) are otherwise kept. Writing a 1 to bit 4 does not clear it.
- R3: A write loads bits 31 (run), 30 (no-descriptor-fetch), 29 (stop irq enable), 28 (end-of-receive irq enable), 27 (end-of-receive jump), 26 (end-of-receive stop) and 23 (request-after-stop irq enable) from the written value. Bits 22, 24 and 25 always read 0. `run_o`, `nodesc_o`, `eor_jump_o` and `eor_stop_o` follow bits 31, 30, 27 and 26.
- R4: A write clears the stopped flag when it writes run (bit 31) as 1 or stop irq enable (bit 29) as 1.
- R5: A write that has neither run (bit 31) nor mask-run (bit 22) set leaves the stopped flag set. This takes priority over R4.
- R6: Writing bit 24 clears the compare flag (bit 10). Writing bit 25 sets it. When both are written, the flag ends set.
- R7: The read value has bit 8 equal to the channel's `req_i` level in the same cycle. Bit 8 is not stored.
- R8: Event pulses set flags in the next cycle: bus error sets bit 0, start bit 1, end bit 2, stop bit 3, request-after-stop bit 4 and end-of-receive bit 9. An event wins over a clearing write in the same cycle. A falling edge of the channel's `req_i` clears bit 4.
- R9: A channel's interrupt bit is (bit3 & bit29) | (bit9 & bit28) | (bit4 & bit23) | bit1 | bit2. The bus error and compare flags do not contribute.
- R10: `sum_o[i]` is channel i's interrupt bit, and `irq_o` is the OR of all bits of `sum_o`.
- R11: A write or event to one channel leaves every other channel's word unchanged. A write to a channel number at or above `NUM_CH` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe for the status word |
| wr_ch_i | input | CH_W | Channel being written |
| wr_data_i | input | 32 | Write value |
| rd_ch_i | input | CH_W | Channel being read |
| rd_data_o | output | 32 | Status word of `rd_ch_i`, with the live request in bit 8 |
| req_i | input | NUM_CH | Per-channel request levels |
| evt_start_i | input | NUM_CH | Start event pulses |
| evt_end_i | input | NUM_CH | End event pulses |
| evt_stop_i | input | NUM_CH | Stopped event pulses |
| evt_eor_i | input | NUM_CH | End-of-receive event pulses |
| evt_ras_i | input | NUM_CH | Request-after-stop event pulses |
| evt_berr_i | input | NUM_CH | Bus error event pulses |
| run_o | output | NUM_CH | Per-channel run bit |
| nodesc_o | output | NUM_CH | Per-channel no-descriptor-fetch bit |
| eor_stop_o | output | NUM_CH | Per-channel stop-on-end-of-receive bit |
| eor_jump_o | output | NUM_CH | Per-channel jump-on-end-of-receive bit |
| sum_o | output | NUM_CH | Per-channel interrupt summary |
| irq_o | output | 1 | Combined interrupt |

## Verification
Directed writes test how the stopped flag reacts to each combination of run, mask-run and stop enable. This separates the clearing rule of R4 from the forcing rule of R5. Other directed writes set both compare strobes together, which shows which strobe has priority. Event pulses that arrive in the same cycle as a clearing write show that events win. Enabled and disabled causes are tried side by side, so an interrupt term that ignores its enable, or a bus error that reaches the summary, is detected. Constrained random writes, events and request levels across all channels, compared against a reference model after every cycle, catch writes or events that leak into other channels and request-after-stop flags that clear at the wrong time.

// File: rtl/dma_stat_pkg.sv
package dma_stat_pkg;
  localparam int unsigned DW = 32;

  localparam int unsigned B_BERR     = 0;
  localparam int unsigned B_START    = 1;
  localparam int unsigned B_END      = 2;
  localparam int unsigned B_STOP     = 3;
  localparam int unsigned B_RAS      = 4;
  localparam int unsigned B_REQ      = 8;
  localparam int unsigned B_EOR      = 9;
  localparam int unsigned B_CMP      = 10;
  localparam int unsigned B_MASKRUN  = 22;
  localparam int unsigned B_RAS_EN   = 23;
  localparam int unsigned B_CMP_CLR  = 24;
  localparam int unsigned B_CMP_SET  = 25;
  localparam int unsigned B_EOR_STOP = 26;
  localparam int unsigned B_EOR_JMP  = 27;
  localparam int unsigned B_EOR_EN   = 28;
  localparam int unsigned B_STOP_EN  = 29;
  localparam int unsigned B_NODESC   = 30;
  localparam int unsigned B_RUN      = 31;

  // stored status bits (request-pending bit 8 is live, never stored)
  localparam logic [DW-1:0] KEEP_MASK = 32'h0000_061F;
  localparam logic [DW-1:0] W1C_MASK  = 32'h0000_0207;
  localparam logic [DW-1:0] CTRL_MASK = 32'hFC80_0000;

  function automatic logic chan_irq(input logic [DW-1:0] w);
    return (w[B_STOP] & w[B_STOP_EN]) | (w[B_EOR] & w[B_EOR_EN]) |
           (w[B_RAS] & w[B_RAS_EN]) | w[B_START] | w[B_END];
  endfunction
endpackage

// File: rtl/dma_stat_chan.sv
module dma_stat_chan
  import dma_stat_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wd_i,
  input  logic          req_i,
  input  logic          evt_start_i,
  input  logic          evt_end_i,
  input  logic          evt_stop_i,
  input  logic          evt_eor_i,
  input  logic          evt_ras_i,
  input  logic          evt_berr_i,
  output logic [DW-1:0] st_o,
  output logic          irq_o
);
  logic [DW-1:0] word_q, word_d;
  logic          req_q;
  logic          req_fall;

  assign req_fall = req_q & ~req_i;

  always_comb begin
    word_d = word_q;
    if (wr_i) begin
      word_d = (word_q & KEEP_MASK & ~(wd_i & W1C_MASK)) | (wd_i & CTRL_MASK);
      if (word_d[B_STOP_EN] || wd_i[B_RUN]) word_d[B_STOP] = 1'b0;
      if (!wd_i[B_RUN] && !wd_i[B_MASKRUN]) word_d[B_STOP] = 1'b1;
      if (wd_i[B_CMP_CLR]) word_d[B_CMP] = 1'b0;
      if (wd_i[B_CMP_SET]) word_d[B_CMP] = 1'b1;
    end
    if (req_fall) word_d[B_RAS] = 1'b0;
    // engine events win over any clear in the same cycle
    if (evt_berr_i)  word_d[B_BERR]  = 1'b1;
    if (evt_start_i) word_d[B_START] = 1'b1;
    if (evt_end_i)   word_d[B_END]   = 1'b1;
    if (evt_stop_i)  word_d[B_STOP]  = 1'b1;
    if (evt_ras_i)   word_d[B_RAS]   = 1'b1;
    if (evt_eor_i)   word_d[B_EOR]   = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= DW'(1) << B_STOP;
      req_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      req_q  <= req_i;
    end
  end

  assign st_o  = word_q;
  assign irq_o = chan_irq(word_q);

  assert_w1c_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wd_i[B_START] && !evt_start_i) |=> !word_q[B_START]);
  assert_ctrl_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> ((word_q & CTRL_MASK) == ($past(wd_i) & CTRL_MASK)));
  assert_run_unstops_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wd_i[B_RUN] && !evt_stop_i) |=> !word_q[B_STOP]);
  assert_idle_stops_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wd_i[B_RUN] && !wd_i[B_MASKRUN]) |=> word_q[B_STOP]);
  assert_cmp_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wd_i[B_CMP_SET]) |=> word_q[B_CMP]);
  assert_ras_fall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && !req_i && !evt_ras_i) |=> !word_q[B_RAS]);
endmodule

// File: rtl/dma_stat_sum.sv
module dma_stat_sum #(
  parameter int unsigned NUM_CH = 8
) (
  input  logic [NUM_CH-1:0] ch_irq_i,
  output logic [NUM_CH-1:0] sum_o,
  output logic              irq_o
);
  assign sum_o = ch_irq_i;
  assign irq_o = |ch_irq_i;
endmodule

// File: rtl/dma_stat_agg.sv
module dma_stat_agg
  import dma_stat_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CH_W-1:0]   wr_ch_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic [CH_W-1:0]   rd_ch_i,
  output logic [DW-1:0]     rd_data_o,
  input  logic [NUM_CH-1:0] req_i,
  input  logic [NUM_CH-1:0] evt_start_i,
  input  logic [NUM_CH-1:0] evt_end_i,
  input  logic [NUM_CH-1:0] evt_stop_i,
  input  logic [NUM_CH-1:0] evt_eor_i,
  input  logic [NUM_CH-1:0] evt_ras_i,
  input  logic [NUM_CH-1:0] evt_berr_i,
  output logic [NUM_CH-1:0] run_o,
  output logic [NUM_CH-1:0] nodesc_o,
  output logic [NUM_CH-1:0] eor_stop_o,
  output logic [NUM_CH-1:0] eor_jump_o,
  output logic [NUM_CH-1:0] sum_o,
  output logic              irq_o
);
  logic [DW-1:0]     rd_word [NUM_CH];
  logic [NUM_CH-1:0] ch_irq;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [DW-1:0] st;
    logic          hit;

    assign hit = wr_en_i && (wr_ch_i == CH_W'(i));

    dma_stat_chan u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_i        (hit),
      .wd_i        (wr_data_i),
      .req_i       (req_i[i]),
      .evt_start_i (evt_start_i[i]),
      .evt_end_i   (evt_end_i[i]),
      .evt_stop_i  (evt_stop_i[i]),
      .evt_eor_i   (evt_eor_i[i]),
      .evt_ras_i   (evt_ras_i[i]),
      .evt_berr_i  (evt_berr_i[i]),
      .st_o        (st),
      .irq_o       (ch_irq[i])
    );

    assign rd_word[i]    = st | (DW'(req_i[i]) << B_REQ);
    assign run_o[i]      = st[B_RUN];
    assign nodesc_o[i]   = st[B_NODESC];
    assign eor_stop_o[i] = st[B_EOR_STOP];
    assign eor_jump_o[i] = st[B_EOR_JMP];
  end

  always_comb begin
    rd_data_o = '0;
    if (int'(rd_ch_i) < int'(NUM_CH)) rd_data_o = rd_word[rd_ch_i];
  end

  dma_stat_sum #(.NUM_CH(NUM_CH)) u_sum (
    .ch_irq_i (ch_irq),
    .sum_o    (sum_o),
    .irq_o    (irq_o)
  );

  assert_run_follow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && int'(wr_ch_i) < int'(NUM_CH)) |=> (run_o[$past(wr_ch_i)] == $past(wr_data_i[B_RUN])));
endmodule

// File: tb/dma_stat_agg_tb.sv
module dma_stat_agg_tb;
  localparam int N  = 8;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr = 1'b0;
  logic [CW-1:0] wch = '0, rch = '0;
  logic [31:0]   wd = '0;
  logic [31:0]   rdat;
  logic [N-1:0]  req = '0, e_st = '0, e_en = '0, e_sp = '0, e_eo = '0, e_ra = '0, e_be = '0;
  logic [N-1:0]  run, nodesc, estop, ejump, sum;
  logic          irq;

  logic [31:0]   m_st [N];
  logic [N-1:0]  m_req_q;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  dma_stat_agg #(.NUM_CH(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr), .wr_ch_i(wch), .wr_data_i(wd),
    .rd_ch_i(rch), .rd_data_o(rdat), .req_i(req),
    .evt_start_i(e_st), .evt_end_i(e_en), .evt_stop_i(e_sp), .evt_eor_i(e_eo),
    .evt_ras_i(e_ra), .evt_berr_i(e_be),
    .run_o(run), .nodesc_o(nodesc), .eor_stop_o(estop), .eor_jump_o(ejump),
    .sum_o(sum), .irq_o(irq)
  );

  function automatic logic [31:0] f_write(input logic [31:0] o, input logic [31:0] w);
    logic [31:0] r;
    r = (o & 32'h0000_061F) & ~(w & 32'h0000_0207);
    r = r | (w & 32'hFC80_0000);
    if (w[29] || w[31]) r[3] = 1'b0;
    if (!w[31] && !w[22]) r[3] = 1'b1;
    if (w[24]) r[10] = 1'b0;
    if (w[25]) r[10] = 1'b1;
    return r;
  endfunction

  function automatic logic f_irq(input logic [31:0] s);
    return (s[3] & s[29]) | (s[9] & s[28]) | (s[4] & s[23]) | s[1] | s[2];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // apply current inputs for one cycle, advance model, return at next negedge
  task automatic tick();
    for (int c = 0; c < N; c++) begin
      logic [31:0] t;
      t = m_st[c];
      if (wr && int'(wch) == c) t = f_write(t, wd);
      if (m_req_q[c] && !req[c]) t[4] = 1'b0;
      t = t | {22'b0, e_eo[c], 4'b0, e_ra[c], e_sp[c], e_en[c], e_st[c], e_be[c]};
      m_st[c] = t;
    end
    m_req_q = req;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0; e_st = '0; e_en = '0; e_sp = '0; e_eo = '0; e_ra = '0; e_be = '0;
  endtask

  task automatic wr_ch(input int c, input logic [31:0] v);
    wr = 1'b1; wch = CW'(c); wd = v;
    tick();
  endtask

  task automatic rd_chk(input string tag, input int c, input logic [31:0] exp);
    rch = CW'(c);
    #1;
    chk(tag, rdat, exp);
  endtask

  task automatic model_chk(input string tag);
    logic [N-1:0] es;
    for (int c = 0; c < N; c++) begin
      rch = CW'(c);
      #0.5;
      chk(tag, rdat, m_st[c] | (32'(req[c]) << 8));
      es[c] = f_irq(m_st[c]);
    end
    chk({tag, " sum R10"}, 32'(sum), 32'(es));
    chk({tag, " irq R10"}, 32'(irq), 32'(|es));
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    for (int c = 0; c < N; c++) m_st[c] = 32'h8;
    m_req_q = '0;
    #23 rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int c = 0; c < N; c++) rd_chk("R1 reset word", c, 32'h8);
    chk("R1 reset outputs", {run, nodesc, estop, ejump}, 32'h0);
    chk("R1 reset irq", {23'b0, sum, irq}, 32'h0);

    wr_ch(2, 32'h8000_0000);
    rd_chk("R4 run clears stop", 2, 32'h8000_0000);
    chk("R3 run_o", 32'(run), 32'h04);
    wr_ch(2, 32'h0000_0000);
    rd_chk("R5 idle write stops", 2, 32'h8);
    chk("R3 run_o cleared", 32'(run), 32'h0);

    wr_ch(3, 32'h2040_0000);
    rd_chk("R4 stop enable clears stop", 3, 32'h2000_0000);
    wr_ch(3, 32'h2000_0000);
    rd_chk("R5 priority over stop enable", 3, 32'h2000_0008);
    chk("R9 stopped with enable", 32'(sum), 32'h08);
    chk("R10 irq line", 32'(irq), 32'h1);

    wr_ch(1, 32'h0240_0000);
    rd_chk("R6 compare set", 1, 32'h408);
    wr_ch(1, 32'h0340_0000);
    rd_chk("R6 set wins over clear", 1, 32'h408);
    wr_ch(1, 32'h0140_0000);
    rd_chk("R6 compare clear", 1, 32'h008);

    wr_ch(0, 32'hFFFF_FFFF);
    rd_chk("R3 ctrl load, 22/24/25 read 0", 0, 32'hFC80_0400);
    chk("R3 ctrl outputs", {run[0], nodesc[0], estop[0], ejump[0]}, 32'hF);

    req[4] = 1'b1; tick();
    rd_chk("R7 live request bit", 4, 32'h108);
    req[4] = 1'b0; tick();
    rd_chk("R7 request dropped", 4, 32'h008);

    e_st[5] = 1'b1; e_en[5] = 1'b1; e_eo[5] = 1'b1; e_be[5] = 1'b1; tick();
    rd_chk("R8 events set flags", 5, 32'h20F);
    chk("R9 start/end raise", 32'(sum), 32'h28);
    wr_ch(5, 32'h0040_0207);
    rd_chk("R2 write one to clear", 5, 32'h008);
    e_st[5] = 1'b1; wr = 1'b1; wch = 3'd5; wd = 32'h0040_0002; tick();
    rd_chk("R8 event wins over clear", 5, 32'h00A);
    wr_ch(5, 32'h0040_0002);
    rd_chk("R2 start cleared", 5, 32'h008);

    e_be[6] = 1'b1; tick();
    rd_chk("R8 bus error flag", 6, 32'h009);
    chk("R9 bus error no irq", 32'(sum[6]), 32'h0);
    e_eo[6] = 1'b1; tick();
    chk("R9 eor without enable", 32'(sum[6]), 32'h0);
    wr_ch(6, 32'h1040_0000);
    rd_chk("R9 eor enable word", 6, 32'h1000_0209);
    chk("R9 eor with enable", 32'(sum[6]), 32'h1);

    req[7] = 1'b1; e_ra[7] = 1'b1; tick();
    rd_chk("R8 ras flag", 7, 32'h118);
    wr_ch(7, 32'h0040_0017);
    rd_chk("R2 ras not write-clearable", 7, 32'h118);
    req[7] = 1'b0; tick();
    rd_chk("R8 ras clears on request fall", 7, 32'h008);

    rd_chk("R11 untouched channel", 2, 32'h8);
    model_chk("R11 directed state");

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] v;
      v = $urandom;
      if ($urandom_range(0, 3) == 0) v[31] = 1'b0;
      if ($urandom_range(0, 3) == 0) v[22] = 1'b0;
      wr = ($urandom_range(0, 2) == 0);
      wch = CW'($urandom_range(0, N - 1));
      wd = v;
      e_st = N'($urandom) & N'($urandom) & N'($urandom);
      e_en = N'($urandom) & N'($urandom) & N'($urandom);
      e_sp = N'($urandom) & N'($urandom) & N'($urandom);
      e_eo = N'($urandom) & N'($urandom) & N'($urandom);
      e_ra = N'($urandom) & N'($urandom);
      e_be = N'($urandom) & N'($urandom) & N'($urandom);
      if ($urandom_range(0, 3) == 0) req = N'($urandom);
      tick();
      model_chk("R11 random");
      @(negedge clk);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule